// File: doc/BRIEF.md
# Gated Serial Bitstream Receiver

This block takes a compressed-audio bitstream from an external source over a serial link. The link has three wires: a data line, a receive clock and a bit-enable qualifier. The block assembles the incoming bits into bytes for a downstream decoder. All three inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the edges of the receive clock are found in the system clock domain. For this to work, the receive clock may run at no more than one quarter of the system clock.

A configuration input selects which receive-clock edge samples the data. Bits that arrive while the enable is low are thrown away. The bit counter does not move during those bits, so a byte that was partly assembled carries on once the enable returns.

Finished bytes go into a one-byte holding register, which the decoder drains with a valid/ready handshake. A request output tells the source whether the block can take more data. Two sticky flags record problems: a byte that was lost because the holding register was full, and an enable change while the receive clock was high.

Top module: `sbit_rx`

## Requirements
- R1: Bits are assembled most significant bit first. After eight enabled samples, the first sampled bit appears at `byte_data[7]` and the last at `byte_data[0]`.
- R2: When `cfg_pol` bit 2 is 0 (value 0), data is sampled on the rising edge of `rx_clk`. When bit 2 is 1 (value 4), data is sampled on the falling edge.
- R3: A sampling edge that occurs while `bit_en` is low shifts nothing and does not advance the bit count. Bits already assembled are kept, and assembly continues when `bit_en` returns high.
- R4: Once `byte_valid` is high, it stays high and `byte_data` holds its value until a cycle in which `byte_ready` is high. After that cycle, `byte_valid` is low unless a new byte was loaded in the same cycle.
- R5: A byte that completes while the held byte is valid and not being accepted is dropped. The held byte stays unchanged, and `overflow` goes high and stays high until reset.
- R6: `data_req` is high exactly when the holding register is empty or `byte_ready` is high.
- R7: If the synchronized `bit_en` changes while the synchronized `rx_clk` is high, `proto_err` goes high and stays high until reset.
- R8: A synchronous reset on `rst` (active high) clears the partial byte, the bit count, `byte_valid`, `overflow` and `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pol | input | 3 | Sampling edge select; bit 2 = 0 for rising, 1 for falling |
| rx_clk | input | 1 | Serial receive clock, asynchronous |
| rx_data | input | 1 | Serial data, MSB first, asynchronous |
| bit_en | input | 1 | Bit qualifier; bits are ignored while it is low |
| byte_data | output | BYTE_W | Held byte |
| byte_valid | output | 1 | Holding register is full |
| byte_ready | input | 1 | Downstream accepts the held byte |
| data_req | output | 1 | Source may send more data |
| overflow | output | 1 | Sticky: a byte was lost |
| proto_err | output | 1 | Sticky: enable changed while the receive clock was high |

## Verification
A wrong bit count or a lost partial byte shows up as a wrong byte value on the very next byte. An error in the polarity decode shows up as the other edge's data, because the stimulus drives different values at the rising and the falling edge. A holding register that loads or clears at the wrong time shows up at `byte_valid`, `byte_data` or `data_req` within one system cycle of the handshake. A bad sticky flag shows up when the flag is checked after its triggering event, and again after reset.

// File: rtl/sbit_rx.sv
module sbit_rx #(
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_pol,
  input  logic              rx_clk,
  input  logic              rx_data,
  input  logic              bit_en,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              data_req,
  output logic              overflow,
  output logic              proto_err
);

  logic [2:0]        s1, s2;
  logic              ck_d, en_d;
  logic [BYTE_W-1:0] sh;
  logic [CW-1:0]     cnt;

  wire ck_s  = s2[2];
  wire dat_s = s2[1];
  wire en_s  = s2[0];
  wire edge_hit = cfg_pol[2] ? (ck_d & ~ck_s) : (ck_s & ~ck_d);
  wire take = edge_hit & en_s;
  wire last = (cnt == CW'(BYTE_W - 1));
  wire [BYTE_W-1:0] nxt = {sh[BYTE_W-2:0], dat_s};

  assign data_req = ~byte_valid | byte_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      ck_d <= 1'b0;
      en_d <= 1'b0;
      sh <= '0;
      cnt <= '0;
      byte_data <= '0;
      byte_valid <= 1'b0;
      overflow <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      s1 <= {rx_clk, rx_data, bit_en};
      s2 <= s1;
      ck_d <= ck_s;
      en_d <= en_s;
      if (ck_s && (en_s != en_d)) proto_err <= 1'b1;
      if (take) begin
        sh <= nxt;
        cnt <= last ? '0 : cnt + 1'b1;
      end
      if (take && last) begin
        if (!byte_valid || byte_ready) begin
          byte_data <= nxt;
          byte_valid <= 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end else if (byte_valid && byte_ready) begin
        byte_valid <= 1'b0;
      end
    end
  end

endmodule

module sbit_rx_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] byte_data,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic              data_req,
  input logic              overflow,
  input logic              proto_err
);

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  p_ovf_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(byte_valid) && !$past(byte_ready));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_req_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    !data_req |-> byte_valid);

  p_perr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> !byte_valid && !overflow && !proto_err);

endmodule

bind sbit_rx sbit_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .byte_data(byte_data), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .data_req(data_req), .overflow(overflow),
  .proto_err(proto_err)
);

// File: tb/sbit_rx_bench.sv
module sbit_rx_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_pol = 3'd0;
  logic rx_clk = 1'b0;
  logic rx_data = 1'b0;
  logic bit_en = 1'b1;
  logic byte_ready = 1'b0;
  logic [7:0] byte_data;
  logic byte_valid, data_req, overflow, proto_err;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sbit_rx #(.BYTE_W(8)) u_sbit_rx (
    .clk(clk), .rst(rst), .cfg_pol(cfg_pol), .rx_clk(rx_clk),
    .rx_data(rx_data), .bit_en(bit_en), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .data_req(data_req),
    .overflow(overflow), .proto_err(proto_err)
  );

  // {falling-edge select, byte driven at rising edges, byte driven at falling edges}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'hFE},
    {1'b1, 8'h80, 8'h7F},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic rv, input logic fv);
    @(negedge clk); rx_data = rv;
    cyc(4); rx_clk = 1'b1;
    cyc(2); rx_data = fv;
    cyc(2); rx_clk = 1'b0;
    cyc(4);
  endtask

  task automatic send_byte(input logic [7:0] rb, input logic [7:0] fb);
    for (int i = 7; i >= 0; i--) send_bit(rb[i], fb[i]);
    cyc(6);
  endtask

  task automatic accept();
    @(negedge clk); byte_ready = 1'b1;
    @(negedge clk); byte_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    chk("R8 reset valid", byte_valid, 0);
    chk("R8 reset overflow", overflow, 0);
    chk("R8 reset proto_err", proto_err, 0);
    chk("R6 empty requests", data_req, 1);

    for (int k = 0; k < 6; k++) begin
      logic [16:0] v;
      logic [7:0] exp;
      v = VEC[k];
      exp = v[16] ? v[7:0] : v[15:8];
      cfg_pol = v[16] ? 3'd4 : 3'd0;
      send_byte(v[15:8], v[7:0]);
      chk("R4 byte valid", byte_valid, 1);
      chk("R1/R2 byte value", byte_data, exp);
      chk("R6 full no request", data_req, 0);
      accept();
      chk("R4 cleared after accept", byte_valid, 0);
    end

    // R3: gated bits are dropped and the partial byte survives
    cfg_pol = 3'd0;
    send_bit(1, 1); send_bit(0, 0); send_bit(1, 1); send_bit(1, 1);
    @(negedge clk); bit_en = 1'b0;
    send_bit(0, 0); send_bit(0, 0); send_bit(0, 0);
    @(negedge clk); bit_en = 1'b1;
    send_bit(0, 0); send_bit(1, 1); send_bit(0, 0); send_bit(1, 1);
    cyc(6);
    chk("R3 gated byte value", byte_data, 8'hB5);
    chk("R3 gated byte valid", byte_valid, 1);
    chk("R7 legal enable toggles", proto_err, 0);
    accept();

    // R5: second byte dropped while first one is held
    send_byte(8'h5A, 8'h5A);
    send_byte(8'hC3, 8'hC3);
    chk("R5 held byte kept", byte_data, 8'h5A);
    chk("R5 overflow set", overflow, 1);
    chk("R6 no request when full", data_req, 0);
    @(negedge clk); byte_ready = 1'b1;
    #1 chk("R6 request during accept", data_req, 1);
    @(negedge clk); byte_ready = 1'b0;
    chk("R4 accepted", byte_valid, 0);
    chk("R5 overflow sticky", overflow, 1);

    // R7: enable change while the receive clock is high
    @(negedge clk); rx_clk = 1'b1;
    cyc(4); bit_en = 1'b0;
    cyc(4); rx_clk = 1'b0;
    cyc(4); bit_en = 1'b1;
    cyc(4);
    chk("R7 proto_err set", proto_err, 1);

    // R8: reset clears the partial byte and the sticky flags
    send_bit(1, 1); send_bit(1, 1);
    @(negedge clk); rst = 1'b1;
    cyc(2); rst = 1'b0;
    cyc(2);
    chk("R8 overflow cleared", overflow, 0);
    chk("R8 proto_err cleared", proto_err, 0);
    chk("R8 valid cleared", byte_valid, 0);
    send_byte(8'h69, 8'h69);
    chk("R8 fresh byte after reset", byte_data, 8'h69);
    chk("R8 fresh byte valid", byte_valid, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule